// File: doc/BRIEF.md
# Dual-Channel Loopback Serial Controller

This block offers two serial channels, A and B, each reached through an 8-bit data port and an 8-bit control port. Software programs a channel by first writing a register index into the channel's command register (write register 0) and then writing the value for that register. The pointer falls back to zero after the access. Status is read back through the same control port. Two read registers are available: a line-status byte and an error byte. Channel B also holds an interrupt vector that is shared by both channels.

The data path is an internal loopback. A byte written to a channel's data port is held in a one-byte store and can be read back from the same data port. Writing a second time before that read sets a sticky overrun flag. Every access is a one-cycle strobe that carries an address, a write flag and a write byte. Read data is registered and appears on the cycle after the strobe. There is no line driver, no baud generation and no interrupt chaining.

Top module: `dual_serial_loopback`

## Requirements
- R1: A synchronous active-high reset clears all write registers, pointers, data-valid flags, overrun flags, the vector and `io_rdata` to zero. After reset, a control read returns 0x04 and a data read returns 0x00.
- R2: Only addresses 0xFC to 0xFF are decoded: 0xFC is data A, 0xFD is control A, 0xFE is data B and 0xFF is control B. Any other address leaves all state unchanged, and a read of it returns 0x00.
- R3: A control write while the pointer (bits [2:0] of write register 0) is 0 loads write register 0, and its low three bits become the pointer for the next control access. A control write while the pointer is nonzero stores the byte into the write register it selects and returns the pointer to 0.
- R4: A control read returns the following, according to the pointer: 0 gives read register 0; 1 gives read register 1; 2 gives the vector on channel B and 0x00 on channel A; 3 to 7 give 0x00. After the read the pointer is 0.
- R5: Read register 0 is laid out as follows: bit 0 is set when a byte is held; bit 2 is set when no byte is held; bit 3 is write register 5 bit 7; bit 5 is write register 5 bit 1. Every other bit is 0.
- R6: Read register 1 carries the overrun flag in bit 5 and 0 in every other bit.
- R7: A control write to channel B while its pointer is 2 loads the vector. A write to channel A's register 2 leaves the vector unchanged.
- R8: A data write stores the byte and sets data-valid. If data-valid was already set, the channel's overrun flag is set as well.
- R9: A data read while data-valid is set returns the held byte and clears data-valid. A data read while data-valid is clear returns 0x00.
- R10: Once set, the overrun flag stays set until reset, whatever reads or writes follow.
- R11: `io_rdata` changes only on the clock edge of a read strobe. It holds its value through writes and idle cycles.
- R12: The two channels are independent: an access to one channel never changes the other channel's pointer, registers, data or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_stb | input | 1 | One-cycle access strobe |
| io_we | input | 1 | 1 = write, 0 = read, qualified by io_stb |
| io_addr | input | 8 | Port address |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Registered read byte, valid from the cycle after a read strobe |

## Verification
The hardest state to reach from the ports is a nonzero pointer combined with one particular read or write register. That state only exists for one access after a command-register write, and it vanishes on the next control access of either kind. The bench therefore pairs every probe with a preceding pointer write. It sweeps all eight pointer values for reads on both channels, and all 256 values through write register 5 and through the vector path. After each probe it checks that the following control read falls back to read register 0. Overrun is reached by a back-to-back data write, and the bench then confirms the flag survives further traffic but not a reset.

// File: rtl/serial_pkg.sv
package serial_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_WREGS = 8;
  localparam int VEC_IDX   = 2;
  localparam int MODEM_IDX = 5;
  // read register 0 layout
  localparam int ST_HELD   = 0;
  localparam int ST_EMPTY  = 2;
  localparam int ST_LINE_H = 3;
  localparam int ST_LINE_L = 5;
  // modem-control bits copied from write register 5
  localparam int MC_SRC_H  = 7;
  localparam int MC_SRC_L  = 1;
  // read register 1 layout
  localparam int ERR_OVR   = 5;
endpackage

// File: rtl/serial_ctl_bank.sv
module serial_ctl_bank #(
  parameter int DW    = serial_pkg::BYTE_W,
  parameter int NREG  = serial_pkg::NUM_WREGS,
  parameter int MODEM = serial_pkg::MODEM_IDX,
  localparam int PW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [PW-1:0] ptr_o,
  output logic [DW-1:0] modem_o
);
  logic [DW-1:0] bank_q [NREG];
  logic          unused_fold;

  assign ptr_o   = bank_q[0][PW-1:0];
  assign modem_o = bank_q[MODEM];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) bank_q[i] <= '0;
    end else if (wr_en) begin
      if (ptr_o == '0) begin
        bank_q[0] <= wdata;
      end else begin
        bank_q[ptr_o]     <= wdata;
        bank_q[0][PW-1:0] <= '0;
      end
    end else if (rd_en) begin
      bank_q[0][PW-1:0] <= '0;
    end
  end

  always_comb begin
    unused_fold = ^bank_q[0][DW-1:PW];
    for (int i = 1; i < NREG; i++)
      if (i != MODEM) unused_fold = unused_fold ^ (^bank_q[i]);
  end

  p_ptr_home_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ptr_o != '0) |=> ptr_o == '0);
  p_ptr_load_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ptr_o == '0) |=> ptr_o == $past(wdata[PW-1:0]));
  p_ptr_home_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> ptr_o == '0);
endmodule

// File: rtl/serial_loop_buf.sv
module serial_loop_buf #(
  parameter int DW = serial_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_byte,
  output logic          valid_o,
  output logic          ovr_o
);
  logic [DW-1:0] hold_q;
  logic          valid_q, ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (wr_en) begin
      hold_q  <= wdata;
      valid_q <= 1'b1;
      if (valid_q) ovr_q <= 1'b1;
    end else if (rd_en) begin
      valid_q <= 1'b0;
    end
  end

  assign rd_byte = valid_q ? hold_q : '0;
  assign valid_o = valid_q;
  assign ovr_o   = ovr_q;

  p_valid_set_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_o && rd_byte == $past(wdata));
  p_ovr_set_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && valid_o) |=> ovr_o);
  p_valid_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> !valid_o);
  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    ovr_o |=> ovr_o);
endmodule

// File: rtl/serial_chan.sv
module serial_chan #(
  parameter int DW    = serial_pkg::BYTE_W,
  parameter int NREG  = serial_pkg::NUM_WREGS,
  parameter bit IS_B  = 1'b0,
  localparam int PW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic          ctl_wr,
  input  logic          ctl_rd,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] vec_i,
  output logic [DW-1:0] data_byte,
  output logic [DW-1:0] ctl_byte,
  output logic [PW-1:0] ptr_o
);
  import serial_pkg::*;

  logic [DW-1:0] modem;
  logic          held, ovr;
  logic [DW-1:0] st0, st1;

  serial_ctl_bank #(.DW(DW), .NREG(NREG), .MODEM(MODEM_IDX)) u_bank (
    .clk(clk), .rst(rst), .wr_en(ctl_wr), .rd_en(ctl_rd), .wdata(wdata),
    .ptr_o(ptr_o), .modem_o(modem)
  );

  serial_loop_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst(rst), .wr_en(data_wr), .rd_en(data_rd), .wdata(wdata),
    .rd_byte(data_byte), .valid_o(held), .ovr_o(ovr)
  );

  always_comb begin
    st0            = '0;
    st0[ST_HELD]   = held;
    st0[ST_EMPTY]  = ~held;
    st0[ST_LINE_H] = modem[MC_SRC_H];
    st0[ST_LINE_L] = modem[MC_SRC_L];
    st1            = '0;
    st1[ERR_OVR]   = ovr;
  end

  always_comb begin
    if (ptr_o == PW'(0))            ctl_byte = st0;
    else if (ptr_o == PW'(1))       ctl_byte = st1;
    else if (ptr_o == PW'(VEC_IDX)) ctl_byte = IS_B ? vec_i : '0;
    else                            ctl_byte = '0;
  end

  p_empty_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (ptr_o == '0) |-> (ctl_byte[ST_HELD] != ctl_byte[ST_EMPTY]));
endmodule

// File: rtl/dual_serial_loopback.sv
module dual_serial_loopback #(
  parameter int          DW        = serial_pkg::BYTE_W,
  parameter int          AW        = 8,
  parameter int          NREG      = serial_pkg::NUM_WREGS,
  parameter logic [7:0]  BASE_ADDR = 8'hFC,
  localparam int         PW        = $clog2(NREG),
  localparam int         NCH       = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_stb,
  input  logic          io_we,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata
);
  import serial_pkg::*;

  logic          hit, is_ctl, ch_sel, vec_ld;
  logic [DW-1:0] vec_q;
  logic [DW-1:0] data_byte [NCH];
  logic [DW-1:0] ctl_byte  [NCH];
  logic [PW-1:0] ptr       [NCH];

  assign hit    = io_addr[AW-1:2] == BASE_ADDR[AW-1:2];
  assign is_ctl = io_addr[0];
  assign ch_sel = io_addr[1];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel;
    assign sel = io_stb && hit && (ch_sel == g[0]);
    serial_chan #(.DW(DW), .NREG(NREG), .IS_B(g == 1)) u_ch (
      .clk(clk), .rst(rst),
      .data_wr(sel && io_we && !is_ctl),
      .data_rd(sel && !io_we && !is_ctl),
      .ctl_wr(sel && io_we && is_ctl),
      .ctl_rd(sel && !io_we && is_ctl),
      .wdata(io_wdata), .vec_i(vec_q),
      .data_byte(data_byte[g]), .ctl_byte(ctl_byte[g]), .ptr_o(ptr[g])
    );
  end

  assign vec_ld = io_stb && io_we && hit && is_ctl && ch_sel &&
                  (ptr[1] == PW'(VEC_IDX));

  always_ff @(posedge clk) begin
    if (rst) vec_q <= '0;
    else if (vec_ld) vec_q <= io_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) io_rdata <= '0;
    else if (io_stb && !io_we) begin
      if (!hit)        io_rdata <= '0;
      else if (is_ctl) io_rdata <= ctl_byte[ch_sel];
      else             io_rdata <= data_byte[ch_sel];
    end
  end

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(io_stb && !io_we) |=> $stable(io_rdata));
  p_vec_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !vec_ld |=> $stable(vec_q));
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (io_stb && !io_we && !hit) |=> io_rdata == '0);
  p_ptr_indep_r12: assert property (@(posedge clk) disable iff (rst)
    (io_stb && hit && ch_sel) |=> $stable(ptr[0]));
endmodule

// File: tb/sim_dual_serial_loopback.sv
module sim_dual_serial_loopback;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stb = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  // bench model
  logic [2:0] m_ptr [2];
  logic [7:0] m_wr5 [2];
  logic [7:0] m_hold [2];
  logic       m_val [2];
  logic       m_ovr [2];
  logic [7:0] m_vec;
  logic [7:0] last_rd;

  always #10 clk = ~clk;

  dual_serial_loopback u0 (.clk(clk), .rst(rst), .io_stb(stb), .io_we(we),
    .io_addr(addr), .io_wdata(wdata), .io_rdata(rdata));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin
      m_ptr[c] = 0; m_wr5[c] = 0; m_hold[c] = 0; m_val[c] = 0; m_ovr[c] = 0;
    end
    m_vec = 0; last_rd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] v);
    int c;
    @(negedge clk); stb = 1; we = 1; addr = a; wdata = v;
    @(negedge clk); stb = 0; we = 0;
    c = a[1];
    if (a[7:2] == 6'h3F) begin
      if (!a[0]) begin
        if (m_val[c]) m_ovr[c] = 1;
        m_hold[c] = v; m_val[c] = 1;
      end else if (m_ptr[c] == 0) begin
        m_ptr[c] = v[2:0];
      end else begin
        if (m_ptr[c] == 5) m_wr5[c] = v;
        if (m_ptr[c] == 2 && c == 1) m_vec = v;
        m_ptr[c] = 0;
      end
    end
  endtask

  task automatic do_rd(input logic [7:0] a, input string tag);
    logic [7:0] e;
    int c;
    c = a[1];
    e = 8'h00;
    if (a[7:2] == 6'h3F) begin
      if (!a[0]) begin
        if (m_val[c]) e = m_hold[c];
        m_val[c] = 0;
      end else begin
        case (m_ptr[c])
          3'd0: e = {2'b00, m_wr5[c][1], 1'b0, m_wr5[c][7], ~m_val[c], 1'b0, m_val[c]};
          3'd1: e = {2'b00, m_ovr[c], 5'b0};
          3'd2: e = (c == 1) ? m_vec : 8'h00;
          default: e = 8'h00;
        endcase
        m_ptr[c] = 0;
      end
    end
    @(negedge clk); stb = 1; we = 0; addr = a;
    @(negedge clk); stb = 0;
    last_rd = e;
    check(tag, rdata, e);
  endtask

  initial begin
    model_clear();
    do_reset();
    // R1: reset state
    check("R1 rdata after reset", rdata, 8'h00);
    do_rd(8'hFD, "R1 ctl A after reset");
    do_rd(8'hFF, "R1 ctl B after reset");
    do_rd(8'hFC, "R1 data A after reset");
    do_rd(8'hFE, "R1 data B after reset");

    // R8/R9/R5: every byte through both loopbacks
    for (int c = 0; c < 2; c++)
      for (int v = 0; v < 256; v++) begin
        do_wr(8'hFC | 8'(c << 1), 8'(v));
        do_rd(8'hFD | 8'(c << 1), "R5 held flag");
        do_rd(8'hFC | 8'(c << 1), "R9 loopback byte");
        do_rd(8'hFC | 8'(c << 1), "R9 empty read");
      end

    // R3/R5: all values through write register 5
    for (int c = 0; c < 2; c++)
      for (int v = 0; v < 256; v++) begin
        do_wr(8'hFD | 8'(c << 1), 8'h05);
        do_wr(8'hFD | 8'(c << 1), 8'(v));
        do_rd(8'hFD | 8'(c << 1), "R5 modem bits / R3 pointer return");
      end

    // R4: every pointer value for reads, then fall back
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 8; p++) begin
        do_wr(8'hFD | 8'(c << 1), 8'(p) | 8'hA8);
        do_rd(8'hFD | 8'(c << 1), "R4 pointer read");
        do_rd(8'hFD | 8'(c << 1), "R4 pointer cleared");
      end

    // R7: vector loads only from channel B
    for (int v = 0; v < 256; v++) begin
      do_wr(8'hFF, 8'h02);
      do_wr(8'hFF, 8'(v));
      do_wr(8'hFD, 8'h02);
      do_wr(8'hFD, ~8'(v));
      do_wr(8'hFF, 8'h02);
      do_rd(8'hFF, "R7 vector on B");
      do_wr(8'hFD, 8'h02);
      do_rd(8'hFD, "R4 vector slot on A");
    end

    // R8/R10/R12/R6: overrun on A only, sticky
    do_wr(8'hFC, 8'h11);
    do_wr(8'hFC, 8'h22);
    do_wr(8'hFD, 8'h01);
    do_rd(8'hFD, "R6 overrun on A");
    do_wr(8'hFF, 8'h01);
    do_rd(8'hFF, "R12 no overrun on B");
    do_rd(8'hFE, "R12 B data untouched");
    do_rd(8'hFC, "R8 latest byte kept");
    do_wr(8'hFC, 8'h33);
    do_rd(8'hFC, "R10 traffic after overrun");
    do_wr(8'hFD, 8'h01);
    do_rd(8'hFD, "R10 overrun sticky");
    do_rd(8'hFD, "R5 after overrun");

    // R2: unmapped addresses
    for (int a = 0; a < 252; a++) do_wr(8'(a), 8'(a) ^ 8'h5F);
    for (int a = 0; a < 252; a += 7) do_rd(8'(a), "R2 unmapped read");
    do_rd(8'hFD, "R2 state A unchanged");
    do_rd(8'hFF, "R2 state B unchanged");
    do_rd(8'hFC, "R2 data A unchanged");

    // R11: read data holds across writes and idle
    do_wr(8'hFE, 8'h9C);
    do_rd(8'hFE, "R11 setup read");
    do_wr(8'hFE, 8'h44);
    do_wr(8'hFD, 8'h05);
    repeat (3) @(negedge clk);
    check("R11 rdata held", rdata, last_rd);

    // R1/R10: reset clears overrun, vector, pointer
    do_wr(8'hFF, 8'h02);
    do_reset();
    check("R1 rdata cleared", rdata, 8'h00);
    do_wr(8'hFD, 8'h01);
    do_rd(8'hFD, "R1 overrun cleared");
    do_wr(8'hFF, 8'h02);
    do_rd(8'hFF, "R1 vector cleared");
    do_rd(8'hFF, "R1 status after reset");

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule